// File: doc/BRIEF.md
# Multicast Address Hash Filter

This block decides whether a received Ethernet frame should be kept, judging only by its 48-bit destination address. The address arrives as a stream of six bytes, one per cycle in which `byte_valid` is high, framed by a one-cycle `addr_start` pulse. As the bytes arrive, a running CRC-32 is folded over them. A bit-reversed five-bit slice of that CRC, together with one more CRC bit that picks a half, selects one bit of a 64-bit group table. The table is held as a high and a low 32-bit word.

The decision first checks the promiscuous override. It then checks broadcast handling, which a reject control can turn off. Group (multicast) addresses are decided by the table bit. Individual addresses are accepted only when they match one station address. The result appears one cycle after the sixth byte and is held until the next start pulse.

The same hash path can also fill the table. In add mode, the bit that would have been tested is set instead. A clear input empties both halves, and a load input writes both halves at once. Loading all ones lets every group address through, which suits an all-groups setting or a group list that is too long to hash.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset, `dec_valid` and `accept` are 0 and both table halves read 0.
- R2: For a group address (bit 0 of byte 0 set) that is not all ones, with promiscuous mode off, `accept` equals one table bit. The CRC uses polynomial 0x04C11DB7 and starts at all ones. Bytes are taken byte 0 first, and each byte least-significant bit first. For each bit, the CRC shifts left and is XORed with the polynomial when its old bit 31 differs from the data bit. The bit index is CRC bits [5:1] with their order reversed, so CRC bit 1 becomes index bit 4. CRC bit 0 picks the half: 1 picks `tbl_hi`, 0 picks `tbl_lo`.
- R3: `dec_valid` is still 0 after the clock edge that takes the sixth byte and is 1 after the following edge. `accept` then holds its value while no start pulse arrives.
- R4: A start pulse clears `dec_valid` and `accept` at the next edge and restarts byte collection. Strobes after the sixth byte, and a strobe in the same cycle as a start pulse, are ignored.
- R5: With `promisc` set and add mode off, every address is accepted.
- R6: The all-ones address is accepted when `bcast_reject` is 0 and rejected when it is 1 (promiscuous off).
- R7: An individual address (bit 0 of byte 0 clear) is accepted only when it equals `station_addr`, where byte i sits at bits [8i+7:8i].
- R8: In add mode, the decision edge sets the selected table bit (same index and half as in R2) and leaves all other bits unchanged. `accept` reads 0 for that address.
- R9: `tbl_clear` zeroes both halves at the next edge. It wins over a load and over an add.
- R10: `tbl_load` writes `load_hi` and `load_lo` into the halves. With both halves all ones, every group address is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_start | input | 1 | Begins a new address and drops the held decision |
| byte_valid | input | 1 | Strobe for one address byte |
| byte_data | input | 8 | Address byte, byte 0 first |
| promisc | input | 1 | Accept every address |
| bcast_reject | input | 1 | Reject the all-ones address |
| add_mode | input | 1 | Set the hashed bit instead of testing it |
| station_addr | input | 48 | Own individual address, byte i at bits [8i+7:8i] |
| tbl_clear | input | 1 | Zero both table halves |
| tbl_load | input | 1 | Write both table halves |
| load_hi | input | 32 | Value for the high half |
| load_lo | input | 32 | Value for the low half |
| dec_valid | output | 1 | Decision is present and held |
| accept | output | 1 | Keep the frame |
| tbl_hi | output | 32 | High table half |
| tbl_lo | output | 32 | Low table half |

## Verification
The decision is due exactly two edges after the sixth byte is driven. The bench drives every input on the falling edge. It confirms that `dec_valid` is still low half a cycle after the edge that takes the sixth byte, and it reads `accept` one full cycle later. Table changes from a clear, a load or an add land on a single edge. The bench reads `tbl_hi` and `tbl_lo` on the falling edge that follows, and compares them with a table copy kept in the bench and updated by its own CRC model.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
   // Reason a decision was reached, in priority order.
   typedef enum logic [1:0] {
      RSN_PROMISC = 2'd0,
      RSN_BCAST   = 2'd1,
      RSN_GROUP   = 2'd2,
      RSN_UNICAST = 2'd3
   } mhf_reason_e;

   // Command to the table, resolved by priority.
   typedef enum logic [1:0] {
      TBL_HOLD  = 2'd0,
      TBL_CLEAR = 2'd1,
      TBL_LOAD  = 2'd2,
      TBL_SET   = 2'd3
   } mhf_tbl_cmd_e;
endpackage

// File: rtl/mhf_crc_engine.sv
module mhf_crc_engine #(
   parameter int unsigned          CRC_W     = 32,
   parameter logic [CRC_W-1:0]     POLY      = 32'h04C11DB7,
   parameter int unsigned          BYTE_W    = 8,
   parameter int unsigned          OUT_W     = 6,
   parameter bit                   LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init,
   input  logic              step,
   input  logic [BYTE_W-1:0] data,
   output logic [OUT_W-1:0]  crc_low
);
   if (OUT_W > CRC_W) begin : g_bad_out
      $error("mhf_crc_engine: OUT_W exceeds CRC_W");
   end

   logic [CRC_W-1:0]  crc_q;
   logic [CRC_W-1:0]  crc_nxt;
   logic [BYTE_W-1:0] bit_seq;

   // Bit consumption order is a build option.
   if (LSB_FIRST) begin : g_lsb
      assign bit_seq = data;
   end else begin : g_msb
      for (genvar b = 0; b < BYTE_W; b++) begin : g_rev
         assign bit_seq[b] = data[BYTE_W-1-b];
      end
   end

   always_comb begin
      logic fb;
      crc_nxt = crc_q;
      for (int j = 0; j < BYTE_W; j++) begin
         fb      = crc_nxt[CRC_W-1] ^ bit_seq[j];
         crc_nxt = {crc_nxt[CRC_W-2:0], 1'b0};
         if (fb) crc_nxt = crc_nxt ^ POLY;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     crc_q <= '1;
      else if (init)  crc_q <= '1;
      else if (step)  crc_q <= crc_nxt;
   end

   assign crc_low = crc_q[OUT_W-1:0];

   // R2: a start always leaves the register preset
   a_r2_preset_after_init: assert property (@(posedge clk) disable iff (!rst_n)
      init |=> (crc_q == '1));
   // R4: with no step and no init the register keeps its value
   a_r4_crc_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!init && !step) |=> $stable(crc_q));
endmodule

// File: rtl/mhf_addr_capture.sv
module mhf_addr_capture #(
   parameter int unsigned ADDR_BYTES = 6,
   parameter int unsigned BYTE_W     = 8,
   localparam int unsigned CNT_W     = $clog2(ADDR_BYTES + 1),
   localparam int unsigned ADDR_W    = ADDR_BYTES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              byte_valid,
   input  logic [BYTE_W-1:0] byte_data,
   output logic              take,
   output logic              last_take,
   output logic [ADDR_W-1:0] addr
);
   if (ADDR_BYTES < 1) begin : g_bad_len
      $error("mhf_addr_capture: ADDR_BYTES must be at least 1");
   end

   localparam logic [CNT_W-1:0] FULL = CNT_W'(ADDR_BYTES);

   logic [CNT_W-1:0] cnt_q;

   assign take      = byte_valid && !start && (cnt_q < FULL);
   assign last_take = take && (cnt_q == FULL - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (start)  cnt_q <= '0;
      else if (take)   cnt_q <= cnt_q + 1'b1;
   end

   for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 addr[i*BYTE_W +: BYTE_W] <= '0;
         else if (take && cnt_q == CNT_W'(i))        addr[i*BYTE_W +: BYTE_W] <= byte_data;
      end
   end

   // R4: the byte count never runs past the address length
   a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL);
   // R4: once full, further strobes leave the captured address alone
   a_r4_full_ignores: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == FULL && !start) |=> $stable(addr));
endmodule

// File: rtl/mhf_hash_table.sv
module mhf_hash_table
   import mhf_pkg::*;
#(
   parameter int unsigned HALF_W      = 32,
   parameter bit          REVERSE_IDX = 1'b1,
   localparam int unsigned IDX_W      = $clog2(HALF_W),
   localparam int unsigned SEL_W      = IDX_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SEL_W-1:0]   crc_sel,
   input  mhf_tbl_cmd_e       cmd,
   input  logic [HALF_W-1:0]  load_hi,
   input  logic [HALF_W-1:0]  load_lo,
   output logic               hit,
   output logic [HALF_W-1:0]  tbl_hi,
   output logic [HALF_W-1:0]  tbl_lo
);
   if ((1 << IDX_W) != HALF_W) begin : g_bad_half
      $error("mhf_hash_table: HALF_W must be a power of two");
   end

   logic [IDX_W-1:0] slice;
   logic [IDX_W-1:0] idx;
   logic             pick_hi;

   assign slice   = crc_sel[IDX_W:1];
   assign pick_hi = crc_sel[0];

   if (REVERSE_IDX) begin : g_rev_idx
      for (genvar g = 0; g < IDX_W; g++) begin : g_bit
         assign idx[g] = slice[IDX_W-1-g];
      end
   end else begin : g_straight_idx
      assign idx = slice;
   end

   assign hit = pick_hi ? tbl_hi[idx] : tbl_lo[idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tbl_hi <= '0;
         tbl_lo <= '0;
      end else begin
         unique case (cmd)
            TBL_CLEAR: begin
               tbl_hi <= '0;
               tbl_lo <= '0;
            end
            TBL_LOAD: begin
               tbl_hi <= load_hi;
               tbl_lo <= load_lo;
            end
            TBL_SET: begin
               if (pick_hi) tbl_hi[idx] <= 1'b1;
               else         tbl_lo[idx] <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   // R9: a clear empties both halves
   a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == TBL_CLEAR) |=> (tbl_hi == '0 && tbl_lo == '0));
   // R8: an add leaves the selected bit set
   a_r8_add_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == TBL_SET) |=> hit);
   // R8: an add touches one bit at most
   a_r8_add_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == TBL_SET) |=> ($countones({tbl_hi, tbl_lo} ^ $past({tbl_hi, tbl_lo})) <= 1));
   // R10: with no command the table keeps its contents
   a_r10_table_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == TBL_HOLD) |=> ($stable(tbl_hi) && $stable(tbl_lo)));
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
   import mhf_pkg::*;
#(
   parameter int unsigned      ADDR_BYTES  = 6,
   parameter int unsigned      BYTE_W      = 8,
   parameter int unsigned      CRC_W       = 32,
   parameter logic [CRC_W-1:0] CRC_POLY    = 32'h04C11DB7,
   parameter int unsigned      HALF_W      = 32,
   parameter bit               REVERSE_IDX = 1'b1,
   parameter bit               LSB_FIRST   = 1'b1,
   localparam int unsigned     ADDR_W      = ADDR_BYTES * BYTE_W,
   localparam int unsigned     SEL_W       = $clog2(HALF_W) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_start,
   input  logic              byte_valid,
   input  logic [BYTE_W-1:0] byte_data,
   input  logic              promisc,
   input  logic              bcast_reject,
   input  logic              add_mode,
   input  logic [ADDR_W-1:0] station_addr,
   input  logic              tbl_clear,
   input  logic              tbl_load,
   input  logic [HALF_W-1:0] load_hi,
   input  logic [HALF_W-1:0] load_lo,
   output logic              dec_valid,
   output logic              accept,
   output logic [HALF_W-1:0] tbl_hi,
   output logic [HALF_W-1:0] tbl_lo
);
   if (SEL_W > CRC_W) begin : g_bad_sel
      $error("mcast_hash_filter: table too large for the CRC width");
   end

   logic              take;
   logic              last_take;
   logic [ADDR_W-1:0] addr;
   logic [SEL_W-1:0]  crc_sel;
   logic              hit;
   logic              pending_q;
   mhf_tbl_cmd_e      cmd;
   mhf_reason_e       reason;
   logic              verdict;

   mhf_addr_capture #(
      .ADDR_BYTES (ADDR_BYTES),
      .BYTE_W     (BYTE_W)
   ) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (addr_start),
      .byte_valid (byte_valid),
      .byte_data  (byte_data),
      .take       (take),
      .last_take  (last_take),
      .addr       (addr)
   );

   mhf_crc_engine #(
      .CRC_W     (CRC_W),
      .POLY      (CRC_POLY),
      .BYTE_W    (BYTE_W),
      .OUT_W     (SEL_W),
      .LSB_FIRST (LSB_FIRST)
   ) u_crc (
      .clk     (clk),
      .rst_n   (rst_n),
      .init    (addr_start),
      .step    (take),
      .data    (byte_data),
      .crc_low (crc_sel)
   );

   // Table command, clear first, then load, then add.
   always_comb begin
      if (tbl_clear)                         cmd = TBL_CLEAR;
      else if (tbl_load)                     cmd = TBL_LOAD;
      else if (pending_q && add_mode)        cmd = TBL_SET;
      else                                   cmd = TBL_HOLD;
   end

   mhf_hash_table #(
      .HALF_W      (HALF_W),
      .REVERSE_IDX (REVERSE_IDX)
   ) u_tbl (
      .clk     (clk),
      .rst_n   (rst_n),
      .crc_sel (crc_sel),
      .cmd     (cmd),
      .load_hi (load_hi),
      .load_lo (load_lo),
      .hit     (hit),
      .tbl_hi  (tbl_hi),
      .tbl_lo  (tbl_lo)
   );

   // Classification of the captured address.
   always_comb begin
      if (promisc)           reason = RSN_PROMISC;
      else if (&addr)        reason = RSN_BCAST;
      else if (addr[0])      reason = RSN_GROUP;
      else                   reason = RSN_UNICAST;
      unique case (reason)
         RSN_PROMISC: verdict = 1'b1;
         RSN_BCAST:   verdict = !bcast_reject;
         RSN_GROUP:   verdict = hit;
         default:     verdict = (addr == station_addr);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending_q <= 1'b0;
         dec_valid <= 1'b0;
         accept    <= 1'b0;
      end else if (addr_start) begin
         pending_q <= 1'b0;
         dec_valid <= 1'b0;
         accept    <= 1'b0;
      end else begin
         pending_q <= last_take;
         if (pending_q) begin
            dec_valid <= 1'b1;
            accept    <= add_mode ? 1'b0 : verdict;
         end
      end
   end

   // R3: decision follows the sixth byte by one cycle
   a_r3_valid_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (last_take && !addr_start) |=> (!dec_valid && pending_q));
   a_r3_valid_rises: assert property (@(posedge clk) disable iff (!rst_n)
      (pending_q && !addr_start) |=> dec_valid);
   // R3: the decision is held until a start
   a_r3_decision_held: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !addr_start) |=> (dec_valid && $stable(accept)));
   // R4: a start drops the decision
   a_r4_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      addr_start |=> (!dec_valid && !accept));
   // R5: promiscuous mode accepts whatever arrives
   a_r5_promisc_accepts: assert property (@(posedge clk) disable iff (!rst_n)
      (pending_q && !addr_start && promisc && !add_mode) |=> accept);
   // R8: add mode never reports an accept
   a_r8_add_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (pending_q && !addr_start && add_mode) |=> !accept);
endmodule

// File: tb/mcast_hash_filter_tb_top.sv
module mcast_hash_filter_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        addr_start = 1'b0;
   logic        byte_valid = 1'b0;
   logic [7:0]  byte_data = '0;
   logic        promisc = 1'b0;
   logic        bcast_reject = 1'b0;
   logic        add_mode = 1'b0;
   logic [47:0] station_addr = 48'h0;
   logic        tbl_clear = 1'b0;
   logic        tbl_load = 1'b0;
   logic [31:0] load_hi = '0;
   logic [31:0] load_lo = '0;
   logic        dec_valid;
   logic        accept;
   logic [31:0] tbl_hi;
   logic [31:0] tbl_lo;

   int unsigned n_checks = 0;
   int unsigned n_fail   = 0;
   logic [31:0] m_hi = '0;
   logic [31:0] m_lo = '0;

   always #10 clk = ~clk;

   mcast_hash_filter dut_i (
      .clk (clk), .rst_n (rst_n), .addr_start (addr_start), .byte_valid (byte_valid),
      .byte_data (byte_data), .promisc (promisc), .bcast_reject (bcast_reject),
      .add_mode (add_mode), .station_addr (station_addr), .tbl_clear (tbl_clear),
      .tbl_load (tbl_load), .load_hi (load_hi), .load_lo (load_lo),
      .dec_valid (dec_valid), .accept (accept), .tbl_hi (tbl_hi), .tbl_lo (tbl_lo)
   );

   function automatic logic [31:0] ref_crc(input logic [47:0] a);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int i = 0; i < 6; i++) begin
         for (int j = 0; j < 8; j++) begin
            logic top = c[31];
            c = c << 1;
            if (top != a[8*i + j]) c = c ^ 32'h04C11DB7;
         end
      end
      return c;
   endfunction

   function automatic int ref_idx(input logic [47:0] a);
      logic [31:0] c = ref_crc(a);
      return {c[1], c[2], c[3], c[4], c[5]};
   endfunction

   function automatic logic ref_accept(input logic [47:0] a, input logic pr, input logic br,
                                       input logic [47:0] st, input logic [31:0] hi, input logic [31:0] lo);
      logic [31:0] c = ref_crc(a);
      if (pr) return 1'b1;
      if (a == 48'hFFFF_FFFF_FFFF) return !br;
      if (a[0]) return c[0] ? hi[ref_idx(a)] : lo[ref_idx(a)];
      return a == st;
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Send a full address; checks R3 timing on the way.
   task automatic send_addr(input logic [47:0] a);
      @(negedge clk); addr_start = 1'b1;
      @(negedge clk); addr_start = 1'b0;
      check("R4 start clears valid", {63'd0, dec_valid}, 64'd0);
      for (int i = 0; i < 6; i++) begin
         byte_valid = 1'b1; byte_data = a[8*i +: 8];
         @(negedge clk);
      end
      byte_valid = 1'b0;
      check("R3 not valid yet", {63'd0, dec_valid}, 64'd0);
      @(negedge clk);
      check("R3 valid now", {63'd0, dec_valid}, 64'd1);
   endtask

   task automatic do_add(input logic [47:0] a);
      logic [31:0] c = ref_crc(a);
      add_mode = 1'b1;
      send_addr(a);
      if (c[0]) m_hi[ref_idx(a)] = 1'b1; else m_lo[ref_idx(a)] = 1'b1;
      check("R8 add accept low", {63'd0, accept}, 64'd0);
      check("R8 table hi", {32'd0, tbl_hi}, {32'd0, m_hi});
      check("R8 table lo", {32'd0, tbl_lo}, {32'd0, m_lo});
      add_mode = 1'b0;
   endtask

   task automatic test_addr(input string req, input logic [47:0] a);
      send_addr(a);
      check(req, {63'd0, accept},
            {63'd0, ref_accept(a, promisc, bcast_reject, station_addr, m_hi, m_lo)});
   endtask

   initial begin
      #(200000 * 20);
      n_fail++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
   end

   initial begin
      logic [47:0] a;
      logic [47:0] grp [4];
      void'($urandom(32'd7321));
      station_addr = 48'h5544_3322_1102;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 valid", {63'd0, dec_valid}, 64'd0);
      check("R1 accept", {63'd0, accept}, 64'd0);
      check("R1 tables", {tbl_hi, tbl_lo}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 load, then all-ones passes every group address
      tbl_load = 1'b1; load_hi = 32'hA5A5_0F0F; load_lo = 32'h1234_8001;
      @(negedge clk); tbl_load = 1'b0;
      m_hi = 32'hA5A5_0F0F; m_lo = 32'h1234_8001;
      check("R10 load", {tbl_hi, tbl_lo}, {m_hi, m_lo});
      tbl_load = 1'b1; load_hi = '1; load_lo = '1;
      @(negedge clk); tbl_load = 1'b0; m_hi = '1; m_lo = '1;
      for (int k = 0; k < 4; k++) begin
         a = {$urandom, $urandom}; a[0] = 1'b1;
         test_addr("R10 all groups pass", a);
      end

      // R9 clear beats load
      tbl_clear = 1'b1; tbl_load = 1'b1;
      @(negedge clk); tbl_clear = 1'b0; tbl_load = 1'b0;
      m_hi = '0; m_lo = '0;
      check("R9 clear", {tbl_hi, tbl_lo}, 64'd0);

      // R8 add groups, then R2 they hit
      for (int k = 0; k < 4; k++) begin
         grp[k] = {$urandom, $urandom}; grp[k][0] = 1'b1;
         do_add(grp[k]);
      end
      for (int k = 0; k < 4; k++) begin
         test_addr("R2 added group hits", grp[k]);
         check("R2 added group accept", {63'd0, accept}, 64'd1);
      end

      // R4 bytes after the sixth are ignored
      @(negedge clk); byte_valid = 1'b1; byte_data = 8'hFF;
      @(negedge clk); byte_valid = 1'b0;
      @(negedge clk);
      check("R4 extra byte held accept", {63'd0, accept}, 64'd1);
      check("R4 extra byte held valid", {63'd0, dec_valid}, 64'd1);
      // R4 aborted address restarts cleanly
      @(negedge clk); addr_start = 1'b1;
      @(negedge clk); addr_start = 1'b0; byte_valid = 1'b1; byte_data = 8'h77;
      repeat (3) @(negedge clk);
      byte_valid = 1'b0;
      test_addr("R4 restart", station_addr);

      // R6 broadcast
      test_addr("R6 bcast allowed", 48'hFFFF_FFFF_FFFF);
      check("R6 bcast accept", {63'd0, accept}, 64'd1);
      bcast_reject = 1'b1;
      test_addr("R6 bcast rejected", 48'hFFFF_FFFF_FFFF);
      check("R6 bcast reject", {63'd0, accept}, 64'd0);

      // R7 unicast match and miss
      test_addr("R7 station match", station_addr);
      check("R7 match accept", {63'd0, accept}, 64'd1);
      test_addr("R7 station miss", station_addr ^ 48'h0100_0000_0000);
      check("R7 miss accept", {63'd0, accept}, 64'd0);

      // R5 promiscuous
      promisc = 1'b1;
      test_addr("R5 promisc unicast", 48'h0000_0000_0A00);
      test_addr("R5 promisc bcast", 48'hFFFF_FFFF_FFFF);
      promisc = 1'b0; bcast_reject = 1'b0;

      // R2 random mix against random tables
      for (int k = 0; k < 40; k++) begin
         if (k % 8 == 0) begin
            tbl_load = 1'b1; load_hi = $urandom; load_lo = $urandom;
            @(negedge clk); tbl_load = 1'b0; m_hi = load_hi; m_lo = load_lo;
         end
         a = {$urandom, $urandom};
         if (k % 4 != 3) a[0] = 1'b1;
         else if (k % 8 == 7) a = station_addr;
         promisc = ($urandom % 6) == 0;
         bcast_reject = $urandom % 2;
         test_addr("R2 random", a);
      end

      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
   end
endmodule